// File: doc/BRIEF.md
# Calendar Clock with Alarm Match

This block keeps time of day and date as eight byte-wide fields: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A phase counter advanced by a 32768 Hz tick enable marks off each second. On the last tick of every second the block writes the next second into all fields at once and gives a one-cycle update pulse. It checks the new time against three alarm bytes in the same step, and a match gives a one-cycle alarm pulse in the same cycle as the update pulse.

Every field is held either as packed BCD (tens in bits 7:4, units in bits 3:0) or as plain binary. Hours are held in 24-hour or 12-hour form. The encoding is picked by mode inputs and is applied when a field is decoded, advanced and encoded again. A status output warns software during the last few ticks of each second that an update is about to happen. A freeze input and a three-bit divider control field stop the time from advancing. The top two divider codes also hold the phase counter in reset, so that time restarts on a half-second boundary. A load strobe writes all eight fields at once. The host bus and interrupt gating belong to the surrounding logic.

Top module: `cal_clock`

## Requirements
- R1: After reset, seconds, minutes, hours, year and century read 0x00, and day of week, day of month and month read 0x01. `uip_o`, `upd_o` and `alm_o` are low.
- R2: When `ld_en_i` is high at a clock edge, the eight fields take the bytes of `ld_time_i` at that edge: byte 0 (bits 7:0) is seconds, then minutes, hours, day of week, day of month, month, year, and byte 7 is century. A load wins over an update that falls in the same cycle, and that update gives no pulse.
- R3: While the clock is running, the fields advance by one second on every TICKS_PER_SEC-th accepted tick. `upd_o` is high for exactly that one cycle, and it is high in the same cycle that the new time first appears. Between updates and loads, the fields hold their values. The clock is running when `set_mode_i` is 0 and `div_ctl_i` is 3'b010 or less.
- R4: `uip_o` is high exactly while the clock is running and the phase counter is in the last UIP_TICKS positions before an update.
- R5: While `set_mode_i` is 1, or `div_ctl_i` is above 3'b010, the fields do not advance, and neither `upd_o` nor `uip_o` is asserted.
- R6: While `div_ctl_i[2:1]` is 2'b11, the phase counter is held at the half-second position. After release into a running code with a tick in every cycle, the first update comes TICKS_PER_SEC/2 ticks later.
- R7: When `bin_mode_i` is 1, fields count in plain binary (59 is 0x3B). When it is 0, fields count in BCD (59 is 0x59).
- R8: When `h24_mode_i` is 0, the hour byte holds 12, 1 to 11 in bits 6:0, and bit 7 set means PM. 11:59:59 AM becomes 12 PM (0x92 in BCD), and 11:59:59 PM becomes 12 AM (0x12) of the next day.
- R9: Seconds and minutes wrap 59 to 0. Hours wrap 23 to 0. Day of week wraps 7 to 1. Day of month returns to 1 after the last day of the month (30 for months 4, 6, 9 and 11, and 31 for the other months except February). Month wraps 12 to 1. Year wraps 99 to 0 and carries into the century.
- R10: February has 29 days in leap years and 28 otherwise. The leap test is on the full year, century times 100 plus year: divisible by 4, except century years not divisible by 400.
- R11: `alm_o` pulses together with `upd_o` when the new seconds, minutes and hours bytes each either equal their alarm byte or face an alarm byte whose bits 7:6 are 2'b11, which matches any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 32768 Hz tick enable, one cycle per tick |
| set_mode_i | input | 1 | Freeze: stops time advance and the UIP window |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = BCD fields |
| h24_mode_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| div_ctl_i | input | 3 | Divider control; 3'b010 or less runs, 2'b11 in bits 2:1 holds the divider |
| alm_sec_i | input | 8 | Seconds alarm byte |
| alm_min_i | input | 8 | Minutes alarm byte |
| alm_hour_i | input | 8 | Hours alarm byte |
| ld_en_i | input | 1 | Load strobe for all eight fields |
| ld_time_i | input | 64 | Load value, byte 0 seconds up to byte 7 century |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours |
| dow_o | output | 8 | Day of week |
| dom_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| cent_o | output | 8 | Century |
| uip_o | output | 1 | Update-in-progress warning |
| upd_o | output | 1 | Update-ended pulse |
| alm_o | output | 1 | Alarm-match pulse |

## Verification
The bench builds the block with TICKS_PER_SEC = 16 and UIP_TICKS = 4. At these values one second takes a handful of cycles, the warning window is four cycles wide, and the half-second restart lands on a tick count that is easy to predict. Loading near-boundary times then brings every carry within a few seconds of simulated time: leap and non-leap February ends, the century roll, and the AM/PM turn in both encodings. Ticks also arrive one cycle in three, to show that the second counts ticks and not clock cycles.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
  localparam int NF     = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DOW  = 3;
  localparam int F_DOM  = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;
  localparam logic [1:0] ANY_CODE = 2'b11;

  typedef logic [NF-1:0][7:0] cal_bytes_t;

  function automatic logic [6:0] fld_dec(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] fld_enc(input logic [6:0] n, input logic bin);
    logic [6:0] tens, units;
    tens  = n / 7'd10;
    units = n % 7'd10;
    if (bin) return {1'b0, n};
    return {tens[3:0], units[3:0]};
  endfunction

  // hour byte to 0..23
  function automatic logic [4:0] hr_dec(input logic [7:0] v, input logic bin, input logic h24);
    logic [6:0] raw;
    logic [4:0] base;
    raw  = fld_dec({1'b0, v[6:0]}, bin);
    base = (raw[4:0] == 5'd12) ? 5'd0 : raw[4:0];
    if (h24) return raw[4:0];
    return v[7] ? base + 5'd12 : base;
  endfunction

  function automatic logic [7:0] hr_enc(input logic [4:0] h, input logic bin, input logic h24);
    logic [4:0] r;
    r = (h >= 5'd12) ? h - 5'd12 : h;
    if (r == 5'd0) r = 5'd12;
    if (h24) return fld_enc(7'(h), bin);
    return fld_enc(7'(r), bin) | {(h >= 5'd12), 7'd0};
  endfunction

  function automatic logic leap_year(input logic [6:0] yr, input logic [6:0] cen);
    if (yr != 7'd0) return yr[1:0] == 2'b00;
    return cen[1:0] == 2'b00;
  endfunction

  function automatic logic [4:0] month_days(input logic [6:0] mon, input logic leap);
    case (mon)
      7'd2:                       return leap ? 5'd29 : 5'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 5'd30;
      default:                    return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_divider.sv
`timescale 1ns/1ps
module cal_divider #(
  parameter int TICKS     = 32768,
  parameter int UIP_TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic run_i,
  output logic uip_o,
  output logic step_o
);
  localparam int PW        = $clog2(TICKS);
  localparam int LAST      = TICKS - 1;
  localparam int HALF      = TICKS / 2;
  localparam int UIP_START = TICKS - UIP_TICKS;

  logic [PW-1:0] phase;
  logic          at_last;

  assign at_last = (phase == PW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)      phase <= '0;
    else if (hold_i) phase <= PW'(HALF);
    else if (tick_i) phase <= at_last ? '0 : phase + 1'b1;
  end

  assign step_o = tick_i && !hold_i && run_i && at_last;
  assign uip_o  = run_i && (phase >= PW'(UIP_START));
endmodule

// File: rtl/cal_advance.sv
`timescale 1ns/1ps
module cal_advance
  import cal_pkg::*;
(
  input  cal_bytes_t cur_i,
  input  logic       bin_i,
  input  logic       h24_i,
  output cal_bytes_t nxt_o
);
  logic [6:0] s, m, dw, dm, mo, yr, ce;
  logic [6:0] ns, nm, ndw, ndm, nmo, nyr, nce;
  logic [4:0] h, nh, dim;
  logic       c_sec, c_min, c_hr, c_dom, c_mon, c_yr;

  always_comb begin
    s  = fld_dec(cur_i[F_SEC],  bin_i);
    m  = fld_dec(cur_i[F_MIN],  bin_i);
    h  = hr_dec(cur_i[F_HOUR],  bin_i, h24_i);
    dw = fld_dec(cur_i[F_DOW],  bin_i);
    dm = fld_dec(cur_i[F_DOM],  bin_i);
    mo = fld_dec(cur_i[F_MON],  bin_i);
    yr = fld_dec(cur_i[F_YEAR], bin_i);
    ce = fld_dec(cur_i[F_CENT], bin_i);
    dim = month_days(mo, leap_year(yr, ce));

    c_sec = (s >= 7'd59);
    ns    = c_sec ? 7'd0 : s + 7'd1;
    c_min = c_sec && (m >= 7'd59);
    nm    = c_sec ? ((m >= 7'd59) ? 7'd0 : m + 7'd1) : m;
    c_hr  = c_min && (h >= 5'd23);
    nh    = c_min ? ((h >= 5'd23) ? 5'd0 : h + 5'd1) : h;
    ndw   = c_hr ? ((dw >= 7'd7) ? 7'd1 : dw + 7'd1) : dw;
    c_dom = c_hr && (dm >= 7'(dim));
    ndm   = c_hr ? (c_dom ? 7'd1 : dm + 7'd1) : dm;
    c_mon = c_dom && (mo >= 7'd12);
    nmo   = c_dom ? (c_mon ? 7'd1 : mo + 7'd1) : mo;
    c_yr  = c_mon && (yr >= 7'd99);
    nyr   = c_mon ? (c_yr ? 7'd0 : yr + 7'd1) : yr;
    nce   = c_yr ? ((ce >= 7'd99) ? 7'd0 : ce + 7'd1) : ce;

    nxt_o[F_SEC]  = fld_enc(ns,  bin_i);
    nxt_o[F_MIN]  = fld_enc(nm,  bin_i);
    nxt_o[F_HOUR] = hr_enc(nh,   bin_i, h24_i);
    nxt_o[F_DOW]  = fld_enc(ndw, bin_i);
    nxt_o[F_DOM]  = fld_enc(ndm, bin_i);
    nxt_o[F_MON]  = fld_enc(nmo, bin_i);
    nxt_o[F_YEAR] = fld_enc(nyr, bin_i);
    nxt_o[F_CENT] = fld_enc(nce, bin_i);
  end
endmodule

// File: rtl/cal_alarm.sv
`timescale 1ns/1ps
module cal_alarm
  import cal_pkg::*;
#(
  parameter int NA = 3
) (
  input  logic [NA-1:0][7:0] val_i,
  input  logic [NA-1:0][7:0] alm_i,
  output logic               hit_o
);
  logic [NA-1:0] fld_ok;

  for (genvar g = 0; g < NA; g++) begin : g_fld
    assign fld_ok[g] = (alm_i[g][7:6] == ANY_CODE) || (alm_i[g] == val_i[g]);
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/cal_clock.sv
`timescale 1ns/1ps
module cal_clock
  import cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        set_mode_i,
  input  logic        bin_mode_i,
  input  logic        h24_mode_i,
  input  logic [2:0]  div_ctl_i,
  input  logic [7:0]  alm_sec_i,
  input  logic [7:0]  alm_min_i,
  input  logic [7:0]  alm_hour_i,
  input  logic        ld_en_i,
  input  logic [63:0] ld_time_i,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  dow_o,
  output logic [7:0]  dom_o,
  output logic [7:0]  mon_o,
  output logic [7:0]  year_o,
  output logic [7:0]  cent_o,
  output logic        uip_o,
  output logic        upd_o,
  output logic        alm_o
);
  localparam logic [2:0] RUN_MAX = 3'b010;
  localparam logic [1:0] HOLD_CODE = 2'b11;

  cal_bytes_t tm, nxt;
  logic       hold, run, step, hit;

  assign hold = (div_ctl_i[2:1] == HOLD_CODE);
  assign run  = !set_mode_i && (div_ctl_i <= RUN_MAX);

  cal_divider #(.TICKS(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold), .run_i(run),
    .uip_o(uip_o), .step_o(step)
  );

  cal_advance u_adv (
    .cur_i(tm), .bin_i(bin_mode_i), .h24_i(h24_mode_i), .nxt_o(nxt)
  );

  cal_alarm #(.NA(3)) u_alm (
    .val_i({nxt[F_HOUR], nxt[F_MIN], nxt[F_SEC]}),
    .alm_i({alm_hour_i, alm_min_i, alm_sec_i}),
    .hit_o(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm        <= '0;
      tm[F_DOW] <= 8'd1;
      tm[F_DOM] <= 8'd1;
      tm[F_MON] <= 8'd1;
      upd_o     <= 1'b0;
      alm_o     <= 1'b0;
    end else begin
      upd_o <= step && !ld_en_i;
      alm_o <= step && !ld_en_i && hit;
      if (ld_en_i)   tm <= ld_time_i;
      else if (step) tm <= nxt;
    end
  end

  assign sec_o  = tm[F_SEC];
  assign min_o  = tm[F_MIN];
  assign hour_o = tm[F_HOUR];
  assign dow_o  = tm[F_DOW];
  assign dom_o  = tm[F_DOM];
  assign mon_o  = tm[F_MON];
  assign year_o = tm[F_YEAR];
  assign cent_o = tm[F_CENT];
endmodule

// File: rtl/cal_clock_chk.sv
`timescale 1ns/1ps
module cal_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       set_mode_i,
  input logic [2:0] div_ctl_i,
  input logic       ld_en_i,
  input logic [7:0] sec_o,
  input logic       uip_o,
  input logic       upd_o,
  input logic       alm_o
);
  // R11
  alarm_with_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alm_o |-> upd_o);

  // R3
  update_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(tick_i && !ld_en_i));

  // R3
  update_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R3
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_o && !$past(ld_en_i)) |-> $stable(sec_o));

  // R5
  frozen_no_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode_i || div_ctl_i > 3'b010) |-> !uip_o);

  // R5
  frozen_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(!set_mode_i && div_ctl_i <= 3'b010));

  // R4
  uip_clear_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> !uip_o);
endmodule

bind cal_clock cal_clock_chk u_cal_clock_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_mode_i(set_mode_i),
  .div_ctl_i(div_ctl_i), .ld_en_i(ld_en_i), .sec_o(sec_o),
  .uip_o(uip_o), .upd_o(upd_o), .alm_o(alm_o)
);

// File: tb/test_cal_clock.sv
`timescale 1ns/1ps
module test_cal_clock;
  localparam int T = 16;
  localparam int U = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, set_mode_i = 1'b0, bin_mode_i = 1'b0, h24_mode_i = 1'b1;
  logic [2:0]  div_ctl_i = 3'b010;
  logic [7:0]  alm_sec_i = 8'h00, alm_min_i = 8'h00, alm_hour_i = 8'h00;
  logic        ld_en_i = 1'b0;
  logic [63:0] ld_time_i = '0;
  logic [7:0]  sec_o, min_o, hour_o, dow_o, dom_o, mon_o, year_o, cent_o;
  logic        uip_o, upd_o, alm_o;

  int n_tests = 0, n_fail = 0;
  int upd_cnt = 0, alm_cnt = 0, uip_cnt = 0;
  bit done_f = 0;

  // reference model state (decoded, 24-hour)
  int ph, ms, mm, mh, mdw, mdm, mmo, myr, mce;
  bit eu, ea;

  always #2 clk = ~clk;

  cal_clock #(.TICKS_PER_SEC(T), .UIP_TICKS(U)) i_cal_clock (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .set_mode_i(set_mode_i),
    .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i), .div_ctl_i(div_ctl_i),
    .alm_sec_i(alm_sec_i), .alm_min_i(alm_min_i), .alm_hour_i(alm_hour_i),
    .ld_en_i(ld_en_i), .ld_time_i(ld_time_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .dom_o(dom_o),
    .mon_o(mon_o), .year_o(year_o), .cent_o(cent_o),
    .uip_o(uip_o), .upd_o(upd_o), .alm_o(alm_o)
  );

  function automatic int b_dec(int v, bit bin);
    return bin ? v : (v / 16) * 10 + (v % 16);
  endfunction
  function automatic int b_enc(int n, bit bin);
    return bin ? n : (n / 10) * 16 + (n % 10);
  endfunction
  function automatic int h_dec(int v, bit bin, bit h24);
    int x = b_dec(v % 128, bin);
    if (h24) return x;
    return (x % 12) + ((v >= 128) ? 12 : 0);
  endfunction
  function automatic int h_enc(int h, bit bin, bit h24);
    int r = h % 12;
    if (h24) return b_enc(h, bin);
    if (r == 0) r = 12;
    return b_enc(r, bin) + ((h >= 12) ? 128 : 0);
  endfunction
  function automatic int days_of(int mo, int yr, int ce);
    int full = ce * 100 + yr;
    bit leap = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic bit fld_match(int al, int v);
    return (al / 64 == 3) || (al == v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; ms = 0; mm = 0; mh = 0; mdw = 1; mdm = 1; mmo = 1; myr = 0; mce = 0;
      eu = 0; ea = 0;
    end else begin
      bit hold, run, stp;
      hold = (div_ctl_i >= 3'b110);
      run  = !set_mode_i && (div_ctl_i <= 3'b010);
      stp  = tick_i && !hold && run && (ph == T - 1);
      if (hold) ph = T / 2;
      else if (tick_i) ph = (ph == T - 1) ? 0 : ph + 1;
      eu = 0; ea = 0;
      if (ld_en_i) begin
        ms  = b_dec(ld_time_i[7:0], bin_mode_i);
        mm  = b_dec(ld_time_i[15:8], bin_mode_i);
        mh  = h_dec(ld_time_i[23:16], bin_mode_i, h24_mode_i);
        mdw = b_dec(ld_time_i[31:24], bin_mode_i);
        mdm = b_dec(ld_time_i[39:32], bin_mode_i);
        mmo = b_dec(ld_time_i[47:40], bin_mode_i);
        myr = b_dec(ld_time_i[55:48], bin_mode_i);
        mce = b_dec(ld_time_i[63:56], bin_mode_i);
      end else if (stp) begin
        ms++;
        if (ms == 60) begin
          ms = 0; mm++;
          if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
              mh = 0; mdw = mdw % 7 + 1; mdm++;
              if (mdm > days_of(mmo, myr, mce)) begin
                mdm = 1; mmo++;
                if (mmo > 12) begin
                  mmo = 1; myr++;
                  if (myr == 100) begin myr = 0; mce = (mce + 1) % 100; end
                end
              end
            end
          end
        end
        eu = 1;
        ea = fld_match(alm_sec_i, b_enc(ms, bin_mode_i)) &&
             fld_match(alm_min_i, b_enc(mm, bin_mode_i)) &&
             fld_match(alm_hour_i, h_enc(mh, bin_mode_i, h24_mode_i));
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_f) begin
      bit run;
      run = !set_mode_i && (div_ctl_i <= 3'b010);
      chk("R9 sec",  sec_o,  b_enc(ms, bin_mode_i));
      chk("R9 min",  min_o,  b_enc(mm, bin_mode_i));
      chk("R8 hour", hour_o, h_enc(mh, bin_mode_i, h24_mode_i));
      chk("R9 dow",  dow_o,  b_enc(mdw, bin_mode_i));
      chk("R10 dom", dom_o,  b_enc(mdm, bin_mode_i));
      chk("R9 mon",  mon_o,  b_enc(mmo, bin_mode_i));
      chk("R9 year", year_o, b_enc(myr, bin_mode_i));
      chk("R9 cent", cent_o, b_enc(mce, bin_mode_i));
      chk("R4 uip",  uip_o,  int'(run && ph >= T - U));
      chk("R3 upd",  upd_o,  int'(eu));
      chk("R11 alm", alm_o,  int'(ea));
      if (upd_o) upd_cnt++;
      if (alm_o) alm_cnt++;
      if (uip_o) uip_cnt++;
    end
  end

  task automatic load(bit bin, bit h24, int s, int m, int h, int dw, int dm, int mo, int yr, int ce);
    @(negedge clk); #1;
    bin_mode_i = bin; h24_mode_i = h24;
    ld_time_i = {8'(ce), 8'(yr), 8'(mo), 8'(dm), 8'(dw), 8'(h), 8'(m), 8'(s)};
    ld_en_i = 1'b1;
    @(negedge clk); #1;
    ld_en_i = 1'b0;
  endtask

  task automatic run_ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1 tick_i = 1'b1;
      for (int j = 1; j < gap; j++) begin
        @(negedge clk); #1 tick_i = 1'b0;
      end
    end
    @(negedge clk); #1 tick_i = 1'b0;
  endtask

  task automatic run_updates(int k, int gap);
    int base = upd_cnt;
    int guard = 0;
    while (upd_cnt - base < k && guard < 4 * T * (k + 1)) begin
      run_ticks(1, gap);
      guard++;
    end
  endtask

  initial begin
    int a0, u0, n;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 sec", sec_o, 8'h00);
    chk("R1 dow", dow_o, 8'h01);
    chk("R1 mon", mon_o, 8'h01);
    chk("R1 upd", upd_o, 0);
    chk("R1 alm", alm_o, 0);

    // R2, R9, R11: year-end rollover in BCD with an exact midnight alarm
    alm_sec_i = 8'h00; alm_min_i = 8'h00; alm_hour_i = 8'h00;
    load(0, 1, 'h58, 'h59, 'h23, 'h07, 'h31, 'h12, 'h99, 'h19);
    chk("R2 sec", sec_o, 8'h58);
    chk("R2 cent", cent_o, 8'h19);
    a0 = alm_cnt;
    run_updates(2, 1);
    chk("R9 hour", hour_o, 8'h00);
    chk("R9 dom", dom_o, 8'h01);
    chk("R9 dow", dow_o, 8'h01);
    chk("R9 year", year_o, 8'h00);
    chk("R9 cent", cent_o, 8'h20);
    chk("R11 exact count", alm_cnt - a0, 1);

    // R4: one full second after an update shows U warning cycles
    u0 = uip_cnt;
    run_ticks(T, 1);
    chk("R4 window", uip_cnt - u0, U);

    // R10 / R9: month ends
    alm_sec_i = 8'h01; alm_min_i = 8'h01; alm_hour_i = 8'h01;
    load(0, 1, 'h59, 'h59, 'h23, 'h01, 'h28, 'h02, 'h00, 'h20);
    run_updates(1, 2);
    chk("R10 2000 leap", dom_o, 8'h29);
    load(0, 1, 'h59, 'h59, 'h23, 'h01, 'h28, 'h02, 'h00, 'h19);
    run_updates(1, 2);
    chk("R10 1900 not leap", mon_o, 8'h03);
    load(0, 1, 'h59, 'h59, 'h23, 'h01, 'h29, 'h02, 'h24, 'h20);
    run_updates(1, 2);
    chk("R10 2024 end", dom_o, 8'h01);
    load(0, 1, 'h59, 'h59, 'h23, 'h01, 'h28, 'h02, 'h23, 'h20);
    run_updates(1, 2);
    chk("R10 2023 end", mon_o, 8'h03);
    load(0, 1, 'h59, 'h59, 'h23, 'h01, 'h30, 'h04, 'h23, 'h20);
    run_updates(1, 2);
    chk("R9 april end", mon_o, 8'h05);

    // R7 binary
    load(1, 1, 58, 59, 23, 3, 30, 6, 99, 20);
    run_updates(1, 1);
    chk("R7 bin sec", sec_o, 8'h3B);
    run_updates(1, 1);
    chk("R7 bin mon", mon_o, 8'h07);
    chk("R7 bin year", year_o, 8'h63);

    // R8 12-hour
    load(0, 0, 'h59, 'h59, 'h11, 'h02, 'h14, 'h03, 'h21, 'h20);
    run_updates(1, 1);
    chk("R8 noon", hour_o, 8'h92);
    load(0, 0, 'h59, 'h59, 'h91, 'h02, 'h15, 'h03, 'h21, 'h20);
    run_updates(1, 1);
    chk("R8 midnight", hour_o, 8'h12);
    chk("R8 next day", dom_o, 8'h16);
    load(1, 0, 59, 59, 'h8C, 2, 15, 3, 21, 20);
    run_updates(1, 1);
    chk("R8 bin 1pm", hour_o, 8'h81);

    // R11 don't-care codes
    alm_sec_i = 8'hC0; alm_min_i = 8'hC0; alm_hour_i = 8'hC0;
    load(0, 1, 'h30, 'h20, 'h10, 'h02, 'h15, 'h03, 'h21, 'h20);
    a0 = alm_cnt;
    run_updates(3, 1);
    chk("R11 all any", alm_cnt - a0, 3);
    alm_hour_i = 8'h05;
    a0 = alm_cnt;
    run_updates(2, 1);
    chk("R11 hour miss", alm_cnt - a0, 0);
    alm_sec_i = 8'h35; alm_min_i = 8'hC0; alm_hour_i = 8'hFF;
    load(0, 1, 'h33, 'h20, 'h10, 'h02, 'h15, 'h03, 'h21, 'h20);
    a0 = alm_cnt;
    run_updates(3, 1);
    chk("R11 sec match", alm_cnt - a0, 1);

    // R5 freeze by SET and by a non-running divider code
    @(negedge clk); #1 set_mode_i = 1'b1;
    u0 = upd_cnt; n = sec_o;
    run_ticks(2 * T, 1);
    chk("R5 set no update", upd_cnt - u0, 0);
    chk("R5 set sec held", sec_o, n);
    @(negedge clk); #1 set_mode_i = 1'b0; div_ctl_i = 3'b100;
    run_ticks(2 * T, 1);
    chk("R5 div no update", upd_cnt - u0, 0);

    // R6 divider hold and half-second release
    @(negedge clk); #1 div_ctl_i = 3'b110;
    run_ticks(3, 1);
    @(negedge clk); #1 div_ctl_i = 3'b010; tick_i = 1'b1;
    n = 0;
    while (!upd_o && n < 4 * T) begin
      @(negedge clk);
      n++;
    end
    #1 tick_i = 1'b0;
    chk("R6 half second", n, T / 2);

    // R3 sparse ticks
    n = sec_o;
    run_updates(2, 3);
    chk("R3 sparse", sec_o, n + 2);

    repeat (3) @(negedge clk);
    done_f = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_f) begin
      done_f = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule